// File: doc/BRIEF.md
# Big-Endian Load/Store Byte Lane Unit

This unit sits between a 32-bit register datapath and a word-wide data memory that is addressed in bytes. On the store side it turns a byte address, an access size and register data into three things. The first is a word-aligned memory address. The second is a set of per-byte write enables. The third is write data with the value copied into every lane that could hold it. The store path is purely combinational, so the memory sees the request in the same cycle.

On the load side it takes the word the memory returned, together with the request's size, signedness and low address bits. It picks the addressed byte or halfword in big-endian order, where byte offset 0 is the most significant byte of the word. It then extends the value to 32 bits, by copying the sign bit or by filling with zeros. The result is registered and comes back one cycle after the request, with a valid strobe. An access whose address does not suit its size raises a misalignment flag. A misaligned store writes nothing.

Access size encoding on `st_size` and `ld_size`: 2'b00 byte, 2'b01 halfword, 2'b10 word, 2'b11 reserved. Write-enable bit i controls data bits 8i+7:8i, so `mem_wen[3]` covers bits 31:24, which is byte offset 0.

Top module: `be_lane_unit`

## Requirements
- R1: `mem_addr` equals `st_addr` with its two low bits forced to zero, so consecutive words sit 4 addresses apart.
- R2: An aligned byte store (size 2'b00) drives `st_data[7:0]` into all four lanes of `mem_wdata`. It asserts only the one enable for offset k, which is `mem_wen[3-k]`; offset 0 gives 4'b1000.
- R3: A halfword store (size 2'b01) with address bit 0 clear drives `st_data[15:0]` into both halves of `mem_wdata`. Offset 0 gives `mem_wen` 4'b1100 and offset 2 gives 4'b0011.
- R4: A word store (size 2'b10) with address bits 1:0 clear passes `st_data` unchanged to `mem_wdata` and asserts `mem_wen` 4'b1111.
- R5: During a store request, `st_misalign` goes high and `mem_wen` is 4'b0000 in each of these cases: a halfword with address bit 0 set, a word with either of address bits 1:0 set, or the reserved size 2'b11. A byte is never misaligned.
- R6: With `st_req` low, `mem_wen` is 4'b0000 and `st_misalign` is low, whatever the other store inputs are.
- R7: A byte load at offset k returns bits 31-8k:24-8k of `ld_word`. When `ld_signed` is 1 the upper 24 bits are copies of the byte's bit 7; when it is 0 they are zero.
- R8: A halfword load returns bits 31:16 at offset 0 and bits 15:0 at offset 2. The upper 16 bits are sign copies when `ld_signed` is 1 and zeros when it is 0.
- R9: A word load returns `ld_word` unchanged, whatever `ld_signed` is.
- R10: `ld_valid` is high in exactly the cycle after a cycle with `ld_req` high. `ld_data` and `ld_misalign` are updated in that same cycle. A misaligned load, under the same rules as R5, returns `ld_misalign` 1 and `ld_data` 0. Without a request, `ld_data` holds its last value.
- R11: While `rst_n` is low, and after reset until the first load, `ld_valid`, `ld_misalign` and `ld_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_req | input | 1 | Store request this cycle |
| st_addr | input | 32 | Store byte address |
| st_size | input | 2 | Store access size |
| st_data | input | 32 | Store register data, value right-aligned |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wen | output | 4 | Per-byte write enables |
| mem_wdata | output | 32 | Lane-replicated write data |
| st_misalign | output | 1 | Store address does not suit its size |
| ld_req | input | 1 | Load data present this cycle |
| ld_size | input | 2 | Load access size |
| ld_signed | input | 1 | 1 for sign extension, 0 for zero fill |
| ld_offset | input | 2 | Low two bits of the load byte address |
| ld_word | input | 32 | Word returned by memory |
| ld_valid | output | 1 | Registered load result is valid |
| ld_data | output | 32 | Extended load value |
| ld_misalign | output | 1 | Load address did not suit its size |

## Verification
The store path has no state, so a wrong lane decode appears at once on `mem_wen` or `mem_wdata` in the same cycle as the request. A swapped lane order shows up as little-endian enables or the wrong byte on loads. The only state in the block is the load register. A fault there shows one cycle after the request: a stuck or late `ld_valid`, a stale `ld_data`, or a misalign flag on the wrong response. Random sizes, offsets and signedness are mixed with directed edge bytes such as 0x80 and 0x7F, so both extension modes are tested on both sides of the sign boundary.

// File: rtl/be_lane_pkg.sv
// Shared types for the big-endian byte lane unit.
// Assumes a two-bit access size field on both load and store requests.
package be_lane_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;
endpackage

// File: rtl/be_align_check.sv
// Decides whether a byte offset suits an access size.
// Assumes a word spans 2**OFF_W bytes; the reserved size always counts as misaligned.
module be_align_check
    import be_lane_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  logic [1:0]       size,
    input  logic [OFF_W-1:0] off,
    output logic             misal
);
    // Alignment rule for each access size
    always_comb begin
        case (acc_size_e'(size))
            SZ_BYTE: misal = 1'b0;
            SZ_HALF: misal = off[0];
            SZ_WORD: misal = |off;
            default: misal = 1'b1;
        endcase
    end
endmodule

// File: rtl/be_store_lane.sv
// Builds the per-byte write enables and the lane-replicated write data for a store.
// Assumes big-endian lanes: byte offset k lives in lane BYTES-1-k, and lane g is bits 8g+7:8g.
module be_store_lane
    import be_lane_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               req,
    input  logic [1:0]         size,
    input  logic [$clog2(DATA_W/8)-1:0] off,
    input  logic               misal,
    input  logic [DATA_W-1:0]  data,
    output logic [DATA_W/8-1:0] wen,
    output logic [DATA_W-1:0]  wdata
);
    localparam int BYTES = DATA_W / 8;
    localparam int OFF_W = $clog2(BYTES);

    genvar g;
    generate
        for (g = 0; g < BYTES; g++) begin : g_lane
            localparam logic [OFF_W-1:0] LANE_OFF = OFF_W'(BYTES - 1 - g);
            logic hit;
            // Does this lane belong to the addressed byte, halfword or word
            always_comb begin
                case (acc_size_e'(size))
                    SZ_BYTE: hit = (off == LANE_OFF);
                    SZ_HALF: hit = (off[OFF_W-1:1] == LANE_OFF[OFF_W-1:1]);
                    SZ_WORD: hit = 1'b1;
                    default: hit = 1'b0;
                endcase
            end
            assign wen[g] = req & ~misal & hit;
        end
    endgenerate

    // Copy the narrow value into every lane position
    always_comb begin
        case (acc_size_e'(size))
            SZ_BYTE: wdata = {BYTES{data[7:0]}};
            SZ_HALF: wdata = {(BYTES/2){data[15:0]}};
            default: wdata = data;
        endcase
    end
endmodule

// File: rtl/be_load_extract.sv
// Selects the addressed byte or halfword from a returned word and extends it.
// Assumes big-endian order: offset 0 is the most significant byte. Misaligned
// halfword offsets are rounded down here; the caller masks the result.
module be_load_extract
    import be_lane_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]          word,
    input  logic [1:0]                 size,
    input  logic [$clog2(DATA_W/8)-1:0] off,
    input  logic                       sgn,
    output logic [DATA_W-1:0]          value
);
    localparam int BYTES = DATA_W / 8;
    localparam int OFF_W = $clog2(BYTES);

    logic [DATA_W-1:0] byte_shift;
    logic [DATA_W-1:0] half_shift;
    logic [7:0]        sel_b;
    logic [15:0]       sel_h;
    logic [OFF_W-1:0]  off_h;

    // Move the addressed byte and halfword down to bit 0
    always_comb begin
        off_h      = {off[OFF_W-1:1], 1'b0};
        byte_shift = word >> (8 * (BYTES - 1 - int'(off)));
        half_shift = word >> (8 * (BYTES - 2 - int'(off_h)));
        sel_b      = byte_shift[7:0];
        sel_h      = half_shift[15:0];
    end

    // Apply sign or zero extension for the access size
    always_comb begin
        case (acc_size_e'(size))
            SZ_BYTE: value = {{(DATA_W-8){sgn & sel_b[7]}}, sel_b};
            SZ_HALF: value = {{(DATA_W-16){sgn & sel_h[15]}}, sel_h};
            default: value = word;
        endcase
    end
endmodule

// File: rtl/be_lane_unit.sv
// Big-endian load/store byte lane unit. The store path is combinational and
// drives the memory in the request cycle; load results are registered and
// returned one cycle later with a valid strobe.
// Assumes a synchronous active-low reset and a memory that is word wide.
module be_lane_unit #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_req,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [1:0]        st_size,
    input  logic [DATA_W-1:0] st_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W/8-1:0] mem_wen,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              st_misalign,
    input  logic              ld_req,
    input  logic [1:0]        ld_size,
    input  logic              ld_signed,
    input  logic [$clog2(DATA_W/8)-1:0] ld_offset,
    input  logic [DATA_W-1:0] ld_word,
    output logic              ld_valid,
    output logic [DATA_W-1:0] ld_data,
    output logic              ld_misalign
);
    localparam int BYTES = DATA_W / 8;
    localparam int OFF_W = $clog2(BYTES);

    logic              st_mis_raw;
    logic              ld_mis_raw;
    logic [DATA_W-1:0] ld_value;

    assign mem_addr    = {st_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign st_misalign = st_req & st_mis_raw;

    be_align_check #(.OFF_W(OFF_W)) u_st_align (
        .size  (st_size),
        .off   (st_addr[OFF_W-1:0]),
        .misal (st_mis_raw)
    );

    be_align_check #(.OFF_W(OFF_W)) u_ld_align (
        .size  (ld_size),
        .off   (ld_offset),
        .misal (ld_mis_raw)
    );

    be_store_lane #(.DATA_W(DATA_W)) u_store (
        .req   (st_req),
        .size  (st_size),
        .off   (st_addr[OFF_W-1:0]),
        .misal (st_mis_raw),
        .data  (st_data),
        .wen   (mem_wen),
        .wdata (mem_wdata)
    );

    be_load_extract #(.DATA_W(DATA_W)) u_load (
        .word  (ld_word),
        .size  (ld_size),
        .off   (ld_offset),
        .sgn   (ld_signed),
        .value (ld_value)
    );

    // Register the load response and its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_valid    <= 1'b0;
            ld_data     <= '0;
            ld_misalign <= 1'b0;
        end else begin
            ld_valid <= ld_req;
            if (ld_req) begin
                ld_misalign <= ld_mis_raw;
                ld_data     <= ld_mis_raw ? '0 : ld_value;
            end
        end
    end
endmodule

// File: rtl/be_lane_unit_chk.sv
// Property checker for the byte lane unit, attached to every instance by bind.
// Assumes the size encoding of be_lane_pkg.
module be_lane_unit_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              st_req,
    input logic [1:0]        st_size,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W/8-1:0] mem_wen,
    input logic              st_misalign,
    input logic              ld_req,
    input logic [1:0]        ld_size,
    input logic              ld_signed,
    input logic              ld_valid,
    input logic [DATA_W-1:0] ld_data,
    input logic              ld_misalign
);
    localparam int OFF_W = $clog2(DATA_W/8);

    assert_addr_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr[OFF_W-1:0] == '0);

    assert_byte_one_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && st_size == 2'b00) |-> $countones(mem_wen) == 1);

    assert_half_two_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && st_size == 2'b01 && !st_misalign) |-> $countones(mem_wen) == 2);

    assert_word_all_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && st_size == 2'b10 && !st_misalign) |-> &mem_wen);

    assert_misalign_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_misalign |-> mem_wen == '0);

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !st_req |-> (mem_wen == '0 && !st_misalign));

    assert_ubyte_zero_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && ld_size == 2'b00 && !ld_signed) |=> ld_data[DATA_W-1:8] == '0);

    assert_uhalf_zero_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && ld_size == 2'b01 && !ld_signed) |=> ld_data[DATA_W-1:16] == '0);

    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ld_req |=> ld_valid);

    assert_valid_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_req |=> !ld_valid);

    assert_misload_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_misalign) |-> ld_data == '0);

    assert_hold_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_req |=> $stable(ld_data));
endmodule

bind be_lane_unit be_lane_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .st_req      (st_req),
    .st_size     (st_size),
    .mem_addr    (mem_addr),
    .mem_wen     (mem_wen),
    .st_misalign (st_misalign),
    .ld_req      (ld_req),
    .ld_size     (ld_size),
    .ld_signed   (ld_signed),
    .ld_valid    (ld_valid),
    .ld_data     (ld_data),
    .ld_misalign (ld_misalign)
);

// File: tb/be_lane_unit_tb.sv
// Self-checking bench: directed corners plus seeded random stores and loads.
module be_lane_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_req = 1'b0;
    logic [31:0] st_addr = '0;
    logic [1:0]  st_size = '0;
    logic [31:0] st_data = '0;
    logic [31:0] mem_addr;
    logic [3:0]  mem_wen;
    logic [31:0] mem_wdata;
    logic        st_misalign;
    logic        ld_req = 1'b0;
    logic [1:0]  ld_size = '0;
    logic        ld_signed = 1'b0;
    logic [1:0]  ld_offset = '0;
    logic [31:0] ld_word = '0;
    logic        ld_valid;
    logic [31:0] ld_data;
    logic        ld_misalign;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] last_data = '0;

    be_lane_unit u_dut (.*);

    always #10 clk = ~clk;

    function automatic bit exp_mis(input logic [1:0] sz, input logic [1:0] off);
        case (sz)
            2'b00:   return 1'b0;
            2'b01:   return off[0];
            2'b10:   return off != 2'b00;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [3:0] exp_wen(input bit req, input logic [1:0] sz, input logic [1:0] off);
        if (!req || exp_mis(sz, off)) return 4'b0000;
        case (sz)
            2'b00:   return 4'b1000 >> off;
            2'b01:   return off[1] ? 4'b0011 : 4'b1100;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] exp_wdata(input logic [1:0] sz, input logic [31:0] d);
        case (sz)
            2'b00:   return {4{d[7:0]}};
            2'b01:   return {2{d[15:0]}};
            default: return d;
        endcase
    endfunction

    function automatic logic [31:0] exp_load(input logic [1:0] sz, input bit sg,
                                             input logic [1:0] off, input logic [31:0] w);
        logic [7:0]  b;
        logic [15:0] h;
        if (exp_mis(sz, off)) return 32'h0;
        case (off)
            2'd0: b = w[31:24];
            2'd1: b = w[23:16];
            2'd2: b = w[15:8];
            default: b = w[7:0];
        endcase
        h = off[1] ? w[15:0] : w[31:16];
        case (sz)
            2'b00:   return sg ? {{24{b[7]}}, b} : {24'h0, b};
            2'b01:   return sg ? {{16{h[15]}}, h} : {16'h0, h};
            default: return w;
        endcase
    endfunction

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Apply a store at the falling edge and check the combinational outputs
    task automatic do_store(input bit req, input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        st_req = req; st_addr = a; st_size = sz; st_data = d;
        #1;
        check32("R1 mem_addr", mem_addr, {a[31:2], 2'b00});
        check32(req ? (sz == 2'b00 ? "R2 wen" : sz == 2'b01 ? "R3 wen" : sz == 2'b10 ? "R4 wen" : "R5 wen")
                    : "R6 wen", {28'h0, mem_wen}, {28'h0, exp_wen(req, sz, a[1:0])});
        check32(req ? "R5 st_misalign" : "R6 st_misalign", {31'h0, st_misalign},
                {31'h0, req & exp_mis(sz, a[1:0])});
        if (req && !exp_mis(sz, a[1:0]))
            check32(sz == 2'b00 ? "R2 wdata" : sz == 2'b01 ? "R3 wdata" : "R4 wdata",
                    mem_wdata, exp_wdata(sz, d));
    endtask

    // Present a load for one cycle; check the registered response a cycle later
    task automatic do_load(input logic [1:0] sz, input bit sg, input logic [1:0] off, input logic [31:0] w);
        logic [31:0] e;
        @(negedge clk);
        ld_req = 1'b1; ld_size = sz; ld_signed = sg; ld_offset = off; ld_word = w;
        e = exp_load(sz, sg, off, w);
        @(negedge clk);
        ld_req = 1'b0;
        check32("R10 ld_valid", {31'h0, ld_valid}, 32'h1);
        check32(exp_mis(sz, off) ? "R10 ld_misalign" : "R10 ld_misalign clear",
                {31'h0, ld_misalign}, {31'h0, exp_mis(sz, off)});
        check32(sz == 2'b00 ? "R7 ld_data" : sz == 2'b01 ? "R8 ld_data" : sz == 2'b10 ? "R9 ld_data" : "R10 ld_data",
                ld_data, e);
        last_data = e;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!done) $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: outputs are zero while reset is held
        check32("R11 ld_valid", {31'h0, ld_valid}, 32'h0);
        check32("R11 ld_data", ld_data, 32'h0);
        check32("R11 ld_misalign", {31'h0, ld_misalign}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check32("R11 ld_valid after release", {31'h0, ld_valid}, 32'h0);

        // Directed store corners: every byte offset, both halves, word, misaligned
        for (int k = 0; k < 4; k++) do_store(1'b1, 32'h1000_0000 + k, 2'b00, 32'hDEAD_BEA5);
        do_store(1'b1, 32'h0000_0102, 2'b01, 32'h1234_ABCD);
        do_store(1'b1, 32'h0000_0100, 2'b01, 32'h1234_ABCD);
        do_store(1'b1, 32'h0000_0101, 2'b01, 32'h1234_ABCD);
        do_store(1'b1, 32'h0000_0103, 2'b01, 32'h1234_ABCD);
        do_store(1'b1, 32'hFFFF_FFFC, 2'b10, 32'hCAFE_F00D);
        do_store(1'b1, 32'hFFFF_FFFE, 2'b10, 32'hCAFE_F00D);
        do_store(1'b1, 32'h0000_0200, 2'b11, 32'hCAFE_F00D);
        do_store(1'b0, 32'h0000_0200, 2'b10, 32'hCAFE_F00D);

        // Directed load corners: sign boundary bytes at every offset
        for (int k = 0; k < 4; k++) begin
            do_load(2'b00, 1'b1, 2'(k), 32'h80_7F_80_7F);
            do_load(2'b00, 1'b0, 2'(k), 32'h80_7F_80_7F);
        end
        do_load(2'b01, 1'b1, 2'd0, 32'h8001_7FFF);
        do_load(2'b01, 1'b1, 2'd2, 32'h8001_7FFF);
        do_load(2'b01, 1'b0, 2'd0, 32'h8001_7FFF);
        do_load(2'b01, 1'b1, 2'd2, 32'h7FFF_8000);
        do_load(2'b01, 1'b1, 2'd3, 32'hFFFF_FFFF);
        do_load(2'b10, 1'b1, 2'd0, 32'h8765_4321);
        do_load(2'b10, 1'b1, 2'd1, 32'h8765_4321);
        do_load(2'b11, 1'b0, 2'd0, 32'h8765_4321);

        // R10: an idle cycle drops valid and holds the data
        @(negedge clk);
        check32("R10 valid drops when idle", {31'h0, ld_valid}, 32'h0);
        check32("R10 data held when idle", ld_data, last_data);

        // Seeded random mix
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r = $urandom();
            do_store(($urandom() % 8) != 0, $urandom(), r[1:0], $urandom());
            do_load(2'($urandom()), 1'($urandom()), 2'($urandom()), $urandom());
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule